// File: doc/BRIEF.md
# Input Capture Timer Channel

This block is one free-running timer channel that can timestamp an external event. A 16-bit up-counter advances on a count enable from a two-stage divider. The first stage divides the system clock by a power of two. The second stage divides that result again, or the divider is bypassed and the count enable comes from edges on an external clock pin. The counter only advances while its start bit is set.

A separate capture pin is synchronised and checked for edges. On the selected edge, the counter value is copied into a capture register. A sticky status flag is set at the same time, and an interrupt is raised when the enable bit allows it. A capture happens whether the counter is running or stopped.

Software reaches the channel over a small 16-bit register bus. The byte-wide control registers use only the upper byte lane. The counter and the capture register are full 16-bit words.

Top module: `capture_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Control registers at addresses 0 to 4 are byte-wide and use bus bits 15:8 only. Bits 7:0 are ignored on write and read as 0. Unused upper bits read as 0. The fields are:
  - prescale exponent: address 0, bits 9:8
  - clock select: address 1, bits 10:8
  - external edge: address 1, bit 11
  - capture edge: address 2, bits 9:8
  - start: address 3, bit 8
  - interrupt enable: address 3, bit 9
  - flag: address 4, bit 8
- R3: With clock select bit 10 at 0, the first stage divides by 2^N, where N is the prescale exponent. The second stage divides by 2^S, where S is select bits 9:8. After C clock cycles with start set, starting from a cleared prescaler, the counter has advanced by floor(C / 2^(N+S)).
- R4: With clock select bit 10 at 1, the counter advances once per edge of `ext_clk_in` after a two-flop synchroniser. The edge is rising when bit 11 is 0 and falling when bit 11 is 1.
- R5: While start is 0 the counter holds its value, even if external clock edges arrive. Both prescaler stages are cleared while start is 0.
- R6: The counter wraps from 0xFFFF to 0x0000.
- R7: The capture edge field selects the trigger: 0 disables capture, 1 selects rising edges of `cap_in`, 2 selects falling edges, and 3 selects both.
- R8: A qualifying edge on `cap_in` is seen on the third rising clock edge after the input changes. The value captured is the counter value held just before that edge, i.e. before any increment that occurs in the same cycle.
- R9: A capture latches the counter value even while the counter is stopped.
- R10: A capture sets the status flag at address 4, bit 8. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged. If a capture and a clear fall in the same cycle, the capture wins.
- R11: `irq` is high exactly when the flag is set and the interrupt enable bit is set.
- R12: The counter at address 5 is writable as a full word. A write takes priority over an increment in the same cycle. The capture register at address 6 is read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ext_clk_in | input | 1 | External counter clock, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| irq | output | 1 | Capture interrupt request |

## Verification
The divider is swept over all sixteen pairs of first-stage exponent and second-stage select for a fixed run length. The expected count is computed as a shift, which separates an error in either stage from a swapped field.

The external clock is driven with five full pulses followed by a sixth rising edge. This gives 6 counts on rising edges and 5 on falling edges, so the edge bit is proven to matter.

Capture is tried with a single pulse against a counter that advances every cycle. The rising mode must return the count at the leading edge plus the synchroniser latency, the falling and both modes the count at the trailing edge, and the disabled mode nothing. A stopped-counter capture and a capture that lands on the same edge as a flag clear cover the remaining orderings.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned PRE_W  = 2;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PRE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CKS = 3'd1;
  localparam logic [ADDR_W-1:0] A_CED = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STA = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAP = 3'd6;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } cap_edge_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre_n;
    logic [SEL_W-1:0] csel;
    logic             ext_fall;
    cap_edge_e        cap_edge;
    logic             start;
    logic             irq_en;
  } ctrl_t;
endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/ct_prescale.sv
module ct_prescale
  import ct_pkg::*;
#(
  parameter int unsigned PW = PRE_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] pre_n,
  input  logic [SW-1:0] csel,
  input  logic          ext_fall_sel,
  input  logic          ext_rise,
  input  logic          ext_fall,
  output logic          cnt_inc
);
  localparam int unsigned P1_W = (1 << PW) - 1;
  localparam int unsigned P2_W = (1 << (SW - 1)) - 1;

  logic [P1_W-1:0] p1_q, p1_d, m1;
  logic [P2_W-1:0] p2_q, p2_d, m2;
  logic            tick1, tick2, ext_tick, use_ext;

  always_comb begin
    for (int i = 0; i < P1_W; i++) m1[i] = (i < int'(pre_n));
    for (int i = 0; i < P2_W; i++) m2[i] = (i < int'(csel[SW-2:0]));
    use_ext  = csel[SW-1];
    tick1    = start && ((p1_q & m1) == m1);
    tick2    = tick1 && ((p2_q & m2) == m2);
    ext_tick = start && (ext_fall_sel ? ext_fall : ext_rise);
    cnt_inc  = use_ext ? ext_tick : tick2;
    p1_d     = start ? p1_q + 1'b1 : '0;
    if (!start)     p2_d = '0;
    else if (tick1) p2_d = p2_q + 1'b1;
    else            p2_d = p2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= '0;
      p2_q <= '0;
    end else begin
      p1_q <= p1_d;
      p2_q <= p2_d;
    end
  end
endmodule

// File: rtl/ct_capture.sv
module ct_capture
  import ct_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cap_edge_e    cap_edge,
  input  logic         cap_rise,
  input  logic         cap_fall,
  input  logic [W-1:0] cnt,
  output logic         cap_evt,
  output logic [W-1:0] cap_q
);
  logic [W-1:0] cap_d;

  always_comb begin
    cap_evt = (cap_rise && (cap_edge == EDGE_RISE || cap_edge == EDGE_BOTH)) ||
              (cap_fall && (cap_edge == EDGE_FALL || cap_edge == EDGE_BOTH));
    cap_d   = cap_evt ? cnt : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end
endmodule

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      cap,
  input  logic              cap_evt,
  output ctrl_t             ctrl_q,
  output logic              flag_q,
  output logic              cnt_wr,
  output logic [W-1:0]      bus_rdata
);
  ctrl_t      ctrl_d;
  logic       flag_d;
  logic [7:0] hb;

  function automatic logic [W-1:0] hi_lane(input logic [7:0] b);
    logic [W-1:0] r;
    r = '0;
    r[W-1 -: 8] = b;
    return r;
  endfunction

  always_comb begin
    hb     = bus_wdata[W-1 -: 8];
    ctrl_d = ctrl_q;
    cnt_wr = bus_wr && (bus_addr == A_CNT);
    if (bus_wr) begin
      case (bus_addr)
        A_PRE: ctrl_d.pre_n = hb[PRE_W-1:0];
        A_CKS: begin
          ctrl_d.csel     = hb[SEL_W-1:0];
          ctrl_d.ext_fall = hb[SEL_W];
        end
        A_CED: ctrl_d.cap_edge = cap_edge_e'(hb[1:0]);
        A_CTL: begin
          ctrl_d.start  = hb[0];
          ctrl_d.irq_en = hb[1];
        end
        default: ;
      endcase
    end
    // capture takes precedence over a write-one clear
    if (cap_evt)                                   flag_d = 1'b1;
    else if (bus_wr && bus_addr == A_STA && hb[0]) flag_d = 1'b0;
    else                                           flag_d = flag_q;
  end

  always_comb begin
    case (bus_addr)
      A_PRE:   bus_rdata = hi_lane(8'(ctrl_q.pre_n));
      A_CKS:   bus_rdata = hi_lane(8'({ctrl_q.ext_fall, ctrl_q.csel}));
      A_CED:   bus_rdata = hi_lane(8'(ctrl_q.cap_edge));
      A_CTL:   bus_rdata = hi_lane(8'({ctrl_q.irq_en, ctrl_q.start}));
      A_STA:   bus_rdata = hi_lane(8'(flag_q));
      A_CNT:   bus_rdata = cnt;
      A_CAP:   bus_rdata = cap;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ct_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              ext_clk_in,
  input  logic              cap_in,
  output logic              irq
);
  logic [1:0]   rs_q;
  logic         rst_n_s;
  ctrl_t        ctrl_q;
  logic         flag_q, cnt_wr, cnt_inc, cap_evt, start_w;
  logic         ext_r, ext_f, cap_r, cap_f;
  logic [W-1:0] cnt_q, cnt_d, cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];
  assign start_w = ctrl_q.start;

  ct_sync_edge #(.STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n_s), .din(ext_clk_in), .rise(ext_r), .fall(ext_f));

  ct_sync_edge #(.STAGES(SYNC_N)) u_cap_sync (
    .clk(clk), .rst_n(rst_n_s), .din(cap_in), .rise(cap_r), .fall(cap_f));

  ct_prescale #(.PW(PRE_W), .SW(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .start(start_w), .pre_n(ctrl_q.pre_n),
    .csel(ctrl_q.csel), .ext_fall_sel(ctrl_q.ext_fall),
    .ext_rise(ext_r), .ext_fall(ext_f), .cnt_inc(cnt_inc));

  ct_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n_s), .cap_edge(ctrl_q.cap_edge),
    .cap_rise(cap_r), .cap_fall(cap_f), .cnt(cnt_q),
    .cap_evt(cap_evt), .cap_q(cap_q));

  ct_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt_q), .cap(cap_q), .cap_evt(cap_evt),
    .ctrl_q(ctrl_q), .flag_q(flag_q), .cnt_wr(cnt_wr), .bus_rdata(bus_rdata));

  always_comb begin
    if (cnt_wr)       cnt_d = bus_wdata;
    else if (cnt_inc) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign irq = flag_q & ctrl_q.irq_en;
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk
  import ct_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic              start,
  input logic              cnt_inc,
  input logic              cnt_wr,
  input logic [W-1:0]      cnt_q,
  input logic              cap_evt,
  input logic [W-1:0]      cap_q,
  input logic              flag
);
  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cnt_wr) |=> $stable(cnt_q));

  // R5
  inc_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> start);

  // R6
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {W{1'b1}} && cnt_inc && !cnt_wr) |=> (cnt_q == '0));

  // R8
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_q)));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_wr && bus_addr == A_STA && bus_wdata[W-8])) |=> flag);
endmodule

bind capture_timer capture_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .start(start_w), .cnt_inc(cnt_inc), .cnt_wr(cnt_wr),
  .cnt_q(cnt_q), .cap_evt(cap_evt), .cap_q(cap_q), .flag(flag_q));

// File: tb/capture_timer_bench.sv
module capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ext_clk_in;
  logic        cap_in;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  localparam logic [2:0] PRE = 3'd0, CKS = 3'd1, CED = 3'd2, CTL = 3'd3,
                         STA = 3'd4, CNT = 3'd5, CAP = 3'd6;

  always #10 clk = ~clk;

  capture_timer u_capture_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
    .cap_in(cap_in), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // run the counter for exactly c clock edges with start set
  task automatic run(input int c);
    wr(CTL, 16'h0100);
    repeat (c - 1) @(negedge clk);
    wr(CTL, 16'h0000);
  endtask

  // pulse cap_in with the counter running at full rate; returns counts at each input change
  task automatic cap_pulse(output logic [15:0] v_r, output logic [15:0] v_f);
    rd(CNT, v_r);
    cap_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(CNT, v_f);
    cap_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, vr, vf;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_clk_in = 1'b0; cap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 16'h0000);
    end
    chk("R1 irq low", {15'b0, irq}, 16'h0000);

    // R2 byte lane and field masking
    wr(PRE, 16'hFFFF); rd(PRE, v); chk("R2 prescale field", v, 16'h0300);
    wr(CED, 16'h02AB); rd(CED, v); chk("R2 capture edge field", v, 16'h0200);
    wr(CKS, 16'h0C55); rd(CKS, v); chk("R2 clock select fields", v, 16'h0C00);
    wr(CTL, 16'h02FF); rd(CTL, v); chk("R2 control fields", v, 16'h0200);
    wr(CTL, 16'h0000); wr(CED, 16'h0000); wr(CKS, 16'h0000);

    // R3 exhaustive two-stage divider sweep
    for (int n = 0; n < 4; n++) begin
      for (int s = 0; s < 4; s++) begin
        wr(CNT, 16'h0000);
        wr(PRE, 16'(n << 8));
        wr(CKS, 16'(s << 8));
        run(150);
        rd(CNT, v);
        chk($sformatf("R3 divide N=%0d S=%0d", n, s), v, 16'(150 >> (n + s)));
      end
    end
    wr(PRE, 16'h0000); wr(CKS, 16'h0000);

    // R5 stopped counter holds on the internal clock
    wr(CNT, 16'h0042);
    repeat (20) @(negedge clk);
    rd(CNT, v); chk("R5 hold while stopped", v, 16'h0042);

    // R6 wrap
    wr(CNT, 16'hFFFE);
    run(3);
    rd(CNT, v); chk("R6 wrap", v, 16'h0001);

    // R12 write wins over increment, then counting resumes
    wr(CTL, 16'h0100);
    repeat (5) @(negedge clk);
    wr(CNT, 16'h0500);
    rd(CNT, v); chk("R12 write over increment", v, 16'h0500);
    @(negedge clk);
    rd(CNT, v); chk("R12 count after write", v, 16'h0501);
    wr(CTL, 16'h0000);

    // R4 external clock, rising then falling edge
    for (int f = 0; f < 2; f++) begin
      wr(CNT, 16'h0000);
      wr(CKS, f ? 16'h0C00 : 16'h0400);
      wr(CTL, 16'h0100);
      for (int p = 0; p < 5; p++) begin
        ext_clk_in = 1'b1; repeat (4) @(negedge clk);
        ext_clk_in = 1'b0; repeat (4) @(negedge clk);
      end
      ext_clk_in = 1'b1; repeat (6) @(negedge clk);
      wr(CTL, 16'h0000);
      ext_clk_in = 1'b0; repeat (6) @(negedge clk);
      rd(CNT, v);
      chk(f ? "R4 external falling" : "R4 external rising", v, f ? 16'd5 : 16'd6);
    end

    // R5 external edges ignored while stopped
    wr(CNT, 16'h0077);
    for (int p = 0; p < 3; p++) begin
      ext_clk_in = 1'b1; repeat (4) @(negedge clk);
      ext_clk_in = 1'b0; repeat (4) @(negedge clk);
    end
    rd(CNT, v); chk("R5 external ignored while stopped", v, 16'h0077);
    wr(CKS, 16'h0000);

    // R7 capture disabled: no capture, no flag
    wr(CNT, 16'h0000);
    wr(CTL, 16'h0100);
    cap_pulse(vr, vf);
    rd(CAP, v); chk("R7 disabled no capture", v, 16'h0000);
    rd(STA, v); chk("R7 disabled no flag", v, 16'h0000);

    // R7 R8 rising
    wr(CED, 16'h0100);
    cap_pulse(vr, vf);
    rd(CAP, v); chk("R8 rising capture value", v, vr + 16'd2);
    rd(STA, v); chk("R10 flag set on capture", v, 16'h0100);
    wr(STA, 16'h0000);
    rd(STA, v); chk("R10 write zero keeps flag", v, 16'h0100);
    wr(STA, 16'h0100);
    rd(STA, v); chk("R10 write one clears flag", v, 16'h0000);

    // R7 falling
    wr(CED, 16'h0200);
    cap_pulse(vr, vf);
    rd(CAP, v); chk("R7 falling capture value", v, vf + 16'd2);

    // R7 both edges: last capture is the trailing edge, two captures differ
    wr(STA, 16'h0100);
    wr(CED, 16'h0300);
    cap_pulse(vr, vf);
    rd(CAP, v); chk("R7 both edges capture value", v, vf + 16'd2);
    rd(STA, v); chk("R7 both edges flag", v, 16'h0100);
    wr(CTL, 16'h0000);

    // R9 capture while stopped
    wr(STA, 16'h0100);
    wr(CED, 16'h0100);
    wr(CNT, 16'h1234);
    cap_pulse(vr, vf);
    rd(CAP, v); chk("R9 capture while stopped", v, 16'h1234);

    // R11 interrupt gating
    chk("R11 irq low with enable clear", {15'b0, irq}, 16'h0000);
    wr(CTL, 16'h0200);
    chk("R11 irq high with flag and enable", {15'b0, irq}, 16'h0001);
    wr(STA, 16'h0100);
    chk("R11 irq low after clear", {15'b0, irq}, 16'h0000);

    // R10 capture wins over a clear on the same edge
    cap_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(STA, 16'h0100);
    rd(STA, v); chk("R10 capture beats clear", v, 16'h0100);
    chk("R11 irq after same-cycle set", {15'b0, irq}, 16'h0001);
    cap_in = 1'b0;
    repeat (6) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule